// File: doc/BRIEF.md
# Dual-Source Time-Base Divider

This block creates the timing taps of a small controller from two clock-enable inputs. One strobe comes from the fast oscillator and one from the slow oscillator, and both are qualified in the base clock domain. Fast strobes pass first through a two-stage prescaler. They then pass through a 21-stage binary divider. The whole chain is built as synchronous counters that step on enables, so there are no ripple clocks.

The divider has two segments. Stages one to six count prescaler carries. Stage seven has a selectable input. In normal mode a select bit chooses between the stage-six carry (fast clock / 2^8) and the slow strobe. In slow or sleep mode the slow strobe is used whatever the select bit says. During the warm-up after a stop release from normal mode, the stage-six carry is used whatever the select bit and mode say. When the fast oscillator is halted, the prescaler and stages one to six hold still.

Every stage is visible in two ways: as a state bit, and as a one-cycle tick that fires when that stage wraps. A separate four-state machine-cycle counter (S0 to S3) steps on the main system clock enable. That enable is the fast strobe in normal mode and the slow strobe in slow or sleep mode.

Top module: `tbase_divider`

## Requirements
- R1: Stage 1 receives one count for every fourth accepted fast strobe. The 2-bit prescaler wraps at that moment, and the low stages change state only on an edge at which the prescaler returns to zero.
- R2: `div_tick[k-1]` (stage k) is high for exactly one cycle. It rises in the cycle after an edge at which stage k received a count while stage k and every stage below it in its segment were 1. The segments are stages 1-6 and stages 7-21, so a tick on a stage other than 1 or 7 implies a tick on the stage below it.
- R3: In normal mode, with warm-up inactive and `sel_slow7`=0, stage 7 counts stage-6 carries. This gives one stage-7 count per 256 fast strobes.
- R4: In normal mode, with warm-up inactive and `sel_slow7`=1, stage 7 counts every `slow_en` strobe directly.
- R5: When `mode_slow` or `mode_sleep` is 1 and warm-up is inactive, stage 7 counts `slow_en` whatever the value of `sel_slow7`.
- R6: When `warmup` is 1, stage 7 counts stage-6 carries whatever the values of `sel_slow7`, `mode_slow` and `mode_sleep`.
- R7: When `mode_sleep`=1, or when `mode_slow`=1 with `fast_osc_off`=1, the prescaler and stages 1-6 hold their state and ticks 1-6 stay low.
- R8: A `clr` pulse zeroes the prescaler, `div_bits` and `div_tick` at the next edge. It does not change `mc_state`.
- R9: After reset, `div_bits`=0, `div_tick`=0 and `mc_state`=0 (S0).
- R10: `mc_state` (0..3 encodes S0..S3) advances by one on each main enable and wraps from S3 to S0. The main enable is `fast_en` in normal mode and `slow_en` when `mode_slow` or `mode_sleep` is 1. Without a main enable, `mc_state` holds.
- R11: After 2^15 stage-7 counts from zero, stage 21 ticks once and `div_bits[20:6]` returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_en | input | 1 | Fast oscillator strobe |
| slow_en | input | 1 | Slow oscillator strobe |
| mode_slow | input | 1 | CPU runs from the slow clock |
| mode_sleep | input | 1 | Sleep with slow clock |
| fast_osc_off | input | 1 | Fast oscillator halted (used with `mode_slow`) |
| warmup | input | 1 | Warm-up after stop release from normal mode |
| sel_slow7 | input | 1 | 1 = stage 7 fed by slow strobe in normal mode |
| clr | input | 1 | Clear request for the prescaler and divider (stop entry/exit) |
| div_bits | output | 21 | Divider state, bit i = stage i+1 |
| div_tick | output | 21 | One-cycle wrap strobes, bit i = stage i+1 |
| mc_state | output | 2 | Machine-cycle state, 0..3 = S0..S3 |

## Verification
The assertions assume the mode inputs are stable levels that change only between clock edges. They also assume that `warmup` is raised only by the caller and never together with `clr`. The bench drives every input at the falling edge, and it holds each combination of modes for hundreds of cycles. Strobe patterns are periodic: every cycle, two of three cycles, or one in five. This exercises carries both on consecutive cycles and when gaps separate them. A long run feeds stage 7 on every cycle until the top stage wraps.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {ST_S0 = 2'd0, ST_S1 = 2'd1, ST_S2 = 2'd2, ST_S3 = 2'd3} mstate_t;
  typedef enum logic {SRC_CHAIN = 1'b0, SRC_SLOW = 1'b1} inj_src_t;

  // Source of stage seven: warm-up forces the chain, slow modes force the slow strobe.
  function automatic inj_src_t pick_source(input logic warm, input logic slowish, input logic sel);
    if (warm) return SRC_CHAIN;
    if (slowish || sel) return SRC_SLOW;
    return SRC_CHAIN;
  endfunction

  function automatic mstate_t next_state(input mstate_t s);
    return mstate_t'(s + 2'd1);
  endfunction
endpackage

// File: rtl/tbd_seg.sv
module tbd_seg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] carry
);
  always_comb begin
    carry[0] = step & q[0];
    for (int i = 1; i < W; i++) carry[i] = carry[i-1] & q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (step)  q <= q + 1'b1;
  end
endmodule

// File: rtl/tbd_inj_mux.sv
module tbd_inj_mux
  import tbd_pkg::*;
(
  input  logic warm,
  input  logic slowish,
  input  logic sel,
  input  logic chain_carry,
  input  logic slow_en,
  output logic inj_step
);
  inj_src_t src;
  always_comb begin
    src      = pick_source(warm, slowish, sel);
    inj_step = (src == SRC_SLOW) ? slow_en : chain_carry;
  end
endmodule

// File: rtl/tbd_mcycle.sv
module tbd_mcycle
  import tbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [1:0] state
);
  mstate_t st_q;
  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= ST_S0;
    else if (adv) st_q <= next_state(st_q);
  end
  assign state = st_q;

  // R10
  mc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> st_q == mstate_t'($past(st_q) + 2'd1));
  // R10
  mc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_q));
endmodule

// File: rtl/tbase_divider.sv
module tbase_divider #(
  parameter int PRE_STAGES = 2,
  parameter int DIV_STAGES = 21,
  parameter int INJ_STAGE  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fast_en,
  input  logic                  slow_en,
  input  logic                  mode_slow,
  input  logic                  mode_sleep,
  input  logic                  fast_osc_off,
  input  logic                  warmup,
  input  logic                  sel_slow7,
  input  logic                  clr,
  output logic [DIV_STAGES-1:0] div_bits,
  output logic [DIV_STAGES-1:0] div_tick,
  output logic [1:0]            mc_state
);
  localparam int LOW_W = INJ_STAGE - 1;
  localparam int HI_W  = DIV_STAGES - LOW_W;

  logic slowish, hold, pre_step, low_step, hi_step, main_adv;
  logic [PRE_STAGES-1:0] pre_q, pre_carry;
  logic [LOW_W-1:0]      low_q, low_carry;
  logic [HI_W-1:0]       hi_q, hi_carry;
  logic [DIV_STAGES-1:0] tick_q;

  assign slowish  = mode_slow | mode_sleep;
  assign hold     = mode_sleep | (mode_slow & fast_osc_off);
  assign pre_step = fast_en & ~hold;
  // Carries are nested, so the reduction equals the top carry.
  assign low_step = &pre_carry;
  assign main_adv = slowish ? slow_en : fast_en;

  tbd_seg #(.W(PRE_STAGES)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(pre_step), .q(pre_q), .carry(pre_carry));

  tbd_seg #(.W(LOW_W)) u_low (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(low_step), .q(low_q), .carry(low_carry));

  tbd_inj_mux u_mux (
    .warm(warmup), .slowish(slowish), .sel(sel_slow7),
    .chain_carry(low_carry[LOW_W-1]), .slow_en(slow_en), .inj_step(hi_step));

  tbd_seg #(.W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(hi_step), .q(hi_q), .carry(hi_carry));

  always_ff @(posedge clk) begin
    if (!rst_n)   tick_q <= '0;
    else if (clr) tick_q <= '0;
    else          tick_q <= {hi_carry, low_carry};
  end

  tbd_mcycle u_mc (.clk(clk), .rst_n(rst_n), .adv(main_adv), .state(mc_state));

  assign div_bits = {hi_q, low_q};
  assign div_tick = tick_q;

  // R1
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr) && low_q != $past(low_q)) |-> pre_q == '0);
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> ($stable(low_q) && $stable(pre_q) && tick_q[LOW_W-1:0] == '0));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_bits == '0 && div_tick == '0 && pre_q == '0));
  // R5
  slow_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q[LOW_W] && $past(slowish && !warmup)) |-> $past(slow_en));
  // R6
  warm_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q[LOW_W] && $past(warmup)) |-> tick_q[LOW_W-1]);

  generate
    for (genvar g = 1; g < DIV_STAGES; g++) begin : g_nest
      if (g != LOW_W) begin : g_chk
        // R2
        tick_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
          tick_q[g] |-> tick_q[g-1]);
      end
    end
  endgenerate
endmodule

// File: tb/tbase_divider_tb_top.sv
`timescale 1ns/1ps
module tbase_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic fast_en, slow_en, mode_slow, mode_sleep, fast_osc_off, warmup, sel_slow7, clr;
  logic [20:0] div_bits, div_tick;
  logic [1:0]  mc_state;

  int checks = 0;
  int fails  = 0;
  int m_pre = 0, m_low = 0, m_hi = 0, m_mc = 0;
  int top_ticks = 0;

  always #5 clk = ~clk;

  tbase_divider dut_i (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en),
    .mode_slow(mode_slow), .mode_sleep(mode_sleep), .fast_osc_off(fast_osc_off),
    .warmup(warmup), .sel_slow7(sel_slow7), .clr(clr),
    .div_bits(div_bits), .div_tick(div_tick), .mc_state(mc_state));

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit fe, input bit se, input bit sl, input bit sp, input bit fo,
                     input bit wm, input bit sel, input bit cl, input string tag);
    logic [20:0] et;
    bit hold, pin, pc, c6, hin, adv;
    @(negedge clk);
    fast_en = fe; slow_en = se; mode_slow = sl; mode_sleep = sp;
    fast_osc_off = fo; warmup = wm; sel_slow7 = sel; clr = cl;
    et = '0;
    if (cl) begin
      m_pre = 0; m_low = 0; m_hi = 0;
    end else begin
      hold = sp || (sl && fo);
      pin  = fe && !hold;
      pc   = pin && (m_pre == 3);
      if (pin) m_pre = (m_pre + 1) % 4;
      c6 = 1'b0;
      if (pc) begin
        for (int k = 1; k <= 6; k++)
          if ((m_low % (1 << k)) == (1 << k) - 1) et[k-1] = 1'b1;
        c6 = (m_low == 63);
        m_low = (m_low + 1) % 64;
      end
      hin = wm ? c6 : ((sl || sp || sel) ? se : c6);
      if (hin) begin
        for (int j = 1; j <= 15; j++)
          if ((m_hi % (1 << j)) == (1 << j) - 1) et[5+j] = 1'b1;
        m_hi = (m_hi + 1) % 32768;
      end
    end
    adv  = (sl || sp) ? se : fe;
    m_mc = (m_mc + int'(adv)) % 4;
    @(posedge clk);
    #1;
    if (div_tick[20]) top_ticks++;
    cmp(tag, "div_tick", longint'(div_tick), longint'(et));
    cmp(tag, "div_bits", longint'(div_bits), longint'({15'(m_hi), 6'(m_low)}));
    cmp("R10", "mc_state", longint'(mc_state), longint'(m_mc));
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fast_en = 0; slow_en = 0; mode_slow = 0; mode_sleep = 0;
    fast_osc_off = 0; warmup = 0; sel_slow7 = 0; clr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    cmp("R9", "div_bits", longint'(div_bits), 0);
    cmp("R9", "div_tick", longint'(div_tick), 0);
    cmp("R9", "mc_state", longint'(mc_state), 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 and R2: normal mode, fast strobe every cycle, chain feeds stage 7
    for (int i = 0; i < 3000; i++) cyc(1, i % 7 == 0, 0, 0, 0, 0, 0, 0, "R3");
    // R1: gapped fast strobes
    for (int i = 0; i < 1500; i++) cyc(i % 3 != 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: nested ticks under a sparse pattern
    for (int i = 0; i < 1200; i++) cyc(i % 2 == 0, i % 4 == 1, 0, 0, 0, 0, 0, 0, "R2");
    // R4: select slow strobe in normal mode
    for (int i = 0; i < 1500; i++) cyc(1, i % 5 == 0, 0, 0, 0, 0, 1, 0, "R4");
    // R5: slow mode with fast osc running, select ignored
    for (int i = 0; i < 1500; i++) cyc(1, i % 3 == 0, 1, 0, 0, 0, 0, 0, "R5");
    // R7: slow mode with fast osc halted
    for (int i = 0; i < 800; i++) cyc(1, i % 2 == 0, 1, 0, 1, 0, i % 2, 0, "R7");
    // R7: sleep
    for (int i = 0; i < 800; i++) cyc(1, i % 4 == 0, 0, 1, 0, 0, 0, 0, "R7");
    // R6: warm-up overrides select and mode
    for (int i = 0; i < 1500; i++) cyc(1, 1, 0, 0, 0, 1, 1, 0, "R6");
    for (int i = 0; i < 600; i++) cyc(1, 1, 1, 0, 0, 1, 0, 0, "R6");
    // R8: clear pulses with activity around them
    for (int i = 0; i < 600; i++) cyc(1, i % 3 == 0, 0, 0, 0, 0, 1, i % 97 == 50, "R8");
    // R11: feed stage 7 every cycle until stage 21 wraps
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    top_ticks = 0;
    for (int i = 0; i < 32768; i++) cyc(0, 1, 0, 0, 0, 0, 1, 0, "R11");
    cmp("R11", "stage21 ticks", top_ticks, 1);
    cmp("R11", "upper bits", longint'(div_bits[20:6]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule